// File: doc/BRIEF.md
# BF16 to single-precision widening converter

This block turns a 16-bit brain-float operand, held in the low half of a floating-point register that is 32 or 64 bits wide, into an exact single-precision value. Before using the operand it checks that the register is properly NaN-boxed, meaning every bit above bit 15 is set. A register that fails this check is read as the canonical quiet NaN.

The conversion itself needs no rounding. The 16-bit pattern becomes the top half of the 32-bit result and the low half is zero-filled. NaN inputs are the one exception: every NaN becomes the canonical single-precision NaN, and a signalling NaN also raises the invalid flag. When the register is 64 bits wide, the result is NaN-boxed again with ones in bits 63:32. A rounding-mode input is accepted for uniformity with other conversions and is ignored.

There is one register stage. An operand presented with `in_valid` high appears on the outputs in the next cycle, with `out_valid` high.

Top module: `bf16_widen_cvt`

## Requirements
- R1: After reset, and until the first accepted operand, `out_valid` and `out_invalid` are 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R3: For a boxed operand that is a normal number, a zero or an infinity, result bits 31:16 equal the operand and bits 15:0 are 0.
- R4: A boxed subnormal operand (exponent field bits 14:7 all zero, fraction bits 6:0 nonzero) is placed the same way, with no renormalization, so that the FP32 value is exact.
- R5: If any register bit above bit 15 is 0, the result bits 31:0 are 0x7FC00000 and `out_invalid` is 0, whatever the low 16 bits hold.
- R6: A boxed NaN operand (bits 14:7 all ones, bits 6:0 nonzero), of either sign and with any payload, gives result bits 31:0 equal to 0x7FC00000.
- R7: `out_invalid` is 1 only for a boxed signalling NaN, which is a NaN with bit 6 clear. Quiet NaNs and non-NaN operands leave it 0, and it is never high while `out_valid` is low.
- R8: With a 64-bit register width, result bits 63:32 are all ones for every result.
- R9: The rounding-mode input has no effect on the result or the flag.
- R10: While `in_valid` is low, `out_reg` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_reg | input | FLEN | Register holding the boxed BF16 operand |
| in_rm | input | 3 | Rounding mode, ignored |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_reg | output | FLEN | NaN-boxed FP32 result |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions assume that `in_valid` and `in_reg` are driven to known levels in every cycle once reset is released. They assume nothing about the order of operands or the spacing between them. The bench therefore changes inputs only on the falling clock edge, keeps `in_valid` at a defined level at all times, and mixes back-to-back operands with idle gaps so that the hold and latency properties are exercised. Operands outside the legal boxing are applied deliberately, because rejecting them is part of the function.

// File: rtl/bf16w_pkg.sv
package bf16w_pkg;
  localparam int BF_W        = 16;
  localparam int SP_W        = 32;
  localparam int BF_EXP_W    = 8;
  localparam int BF_FRAC_W   = 7;
  localparam int PAD_W       = SP_W - BF_W;
  localparam logic [SP_W-1:0] SP_CANON_NAN = 32'h7FC0_0000;
  localparam logic [BF_W-1:0] BF_CANON_NAN = 16'h7FC0;

  typedef struct packed {
    logic                 sign;
    logic [BF_EXP_W-1:0]  expo;
    logic [BF_FRAC_W-1:0] frac;
  } bf16_t;

  function automatic logic bf_is_nan(input bf16_t v);
    return (&v.expo) && (|v.frac);
  endfunction

  function automatic logic bf_is_snan(input bf16_t v);
    return bf_is_nan(v) && !v.frac[BF_FRAC_W-1];
  endfunction

  function automatic logic [SP_W-1:0] bf_place(input bf16_t v);
    return {v, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/bf16w_unbox.sv
module bf16w_unbox
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] reg_in,
  output bf16_t           op,
  output logic            box_ok
);
  assign box_ok = &reg_in[FLEN-1:BF_W];
  assign op     = box_ok ? bf16_t'(reg_in[BF_W-1:0]) : bf16_t'(BF_CANON_NAN);
endmodule

// File: rtl/bf16w_classify.sv
module bf16w_classify
  import bf16w_pkg::*;
(
  input  bf16_t op,
  output logic  is_nan,
  output logic  is_snan
);
  assign is_nan  = bf_is_nan(op);
  assign is_snan = bf_is_snan(op);
endmodule

// File: rtl/bf16w_assemble.sv
module bf16w_assemble
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  bf16_t           op,
  input  logic            is_nan,
  output logic [FLEN-1:0] res
);
  localparam int BOX_W = FLEN - SP_W;
  logic [SP_W-1:0] sp;

  assign sp = is_nan ? SP_CANON_NAN : bf_place(op);

  generate
    if (BOX_W > 0) begin : g_box
      assign res = {{BOX_W{1'b1}}, sp};
    end else begin : g_nobox
      assign res = sp;
    end
  endgenerate
endmodule

// File: rtl/bf16_widen_cvt.sv
module bf16_widen_cvt
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [FLEN-1:0] in_reg,
  input  logic [2:0]      in_rm,
  output logic            out_valid,
  output logic [FLEN-1:0] out_reg,
  output logic            out_invalid
);
  bf16_t           op_w;
  logic            box_ok_w;
  logic            nan_hit_w;
  logic            snan_hit_w;
  logic [FLEN-1:0] res_w;
  logic            unused_rm;

  assign unused_rm = ^in_rm;

  bf16w_unbox #(.FLEN(FLEN)) u_unbox (
    .reg_in (in_reg),
    .op     (op_w),
    .box_ok (box_ok_w)
  );

  bf16w_classify u_class (
    .op      (op_w),
    .is_nan  (nan_hit_w),
    .is_snan (snan_hit_w)
  );

  bf16w_assemble #(.FLEN(FLEN)) u_asm (
    .op     (op_w),
    .is_nan (nan_hit_w),
    .res    (res_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_reg     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && snan_hit_w;
      if (in_valid) out_reg <= res_w;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_flag_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid);
  assert_badbox_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !box_ok_w) |=> (!out_invalid && out_reg[SP_W-1:0] == SP_CANON_NAN));
  assert_nan_canon_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_hit_w) |=> (out_reg[SP_W-1:0] == SP_CANON_NAN));
  assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !nan_hit_w) |=> (out_reg[PAD_W-1:0] == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_reg));

  generate
    if (FLEN > SP_W) begin : g_box_chk
      assert_upper_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&out_reg[FLEN-1:SP_W]));
    end
  endgenerate
endmodule

// File: tb/tb_bf16_widen_cvt.sv
`timescale 1ns/1ps
module tb_bf16_widen_cvt;
  localparam int FLEN = 64;

  typedef struct {
    logic [FLEN-1:0] val;
    logic            inv;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [FLEN-1:0] in_reg = '0;
  logic [2:0]      in_rm = 3'd0;
  logic            out_valid;
  logic [FLEN-1:0] out_reg;
  logic            out_invalid;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  logic [FLEN-1:0] last_val = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bf16_widen_cvt #(.FLEN(FLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_reg(in_reg),
    .in_rm(in_rm), .out_valid(out_valid), .out_reg(out_reg),
    .out_invalid(out_invalid)
  );

  // Reference: written from the requirements, case by case.
  function automatic exp_t model(input logic [FLEN-1:0] r, input string tag);
    exp_t e;
    logic [15:0] b;
    e.tag = tag;
    e.inv = 1'b0;
    b = r[15:0];
    if (r[FLEN-1:16] != {(FLEN-16){1'b1}}) begin
      e.val = {32'hFFFF_FFFF, 32'h7FC0_0000};          // R5
    end else if (b[14:7] == 8'hFF && b[6:0] != 7'd0) begin
      e.val = {32'hFFFF_FFFF, 32'h7FC0_0000};          // R6
      e.inv = (b[6] == 1'b0);                          // R7
    end else begin
      e.val = {32'hFFFF_FFFF, b, 16'h0000};            // R3 R4 R8
    end
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [FLEN-1:0] act, input logic [FLEN-1:0] expv);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
  endtask

  task automatic drive(input logic [FLEN-1:0] r, input logic [2:0] rm, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_reg   = r;
    in_rm    = rm;
    sb.push_back(model(r, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_reg   = {FLEN{1'b0}};
      in_rm    = 3'd5;
    end
  endtask

  task automatic boxed(input logic [15:0] b, input string tag);
    drive({{(FLEN-16){1'b1}}, b}, 3'd0, tag);
  endtask

  // Monitor: compares each result one cycle after its operand (R2).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            checks++;
            fail_line("R2", "unexpected out_valid", {{(FLEN-1){1'b0}}, out_valid}, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (out_reg !== e.val || out_invalid !== e.inv) begin
              fail_line(e.tag, "result", out_reg, e.val);
              $display("FAIL %s flag actual=%0b expected=%0b", e.tag, out_invalid, e.inv);
            end
            last_val = e.val;
          end
        end else if (sb.size() != 0) begin
          checks++;
          fail_line("R2", "missing out_valid", '0, {{(FLEN-1){1'b0}}, 1'b1});
          void'(sb.pop_front());
        end else if (out_invalid !== 1'b0) begin
          checks++;
          fail_line("R7", "flag without valid", {{(FLEN-1){1'b0}}, out_invalid}, '0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_invalid !== 1'b0)
      fail_line("R1", "reset outputs", {{(FLEN-2){1'b0}}, out_valid, out_invalid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (out_valid !== 1'b0 || out_invalid !== 1'b0)
      fail_line("R1", "idle after reset", {{(FLEN-2){1'b0}}, out_valid, out_invalid}, '0);

    // R3: normals, zeros, infinities, back to back
    boxed(16'h3F80, "R3");
    boxed(16'hC020, "R3");
    boxed(16'h0000, "R3");
    boxed(16'h8000, "R3");
    boxed(16'h7F80, "R3");
    boxed(16'hFF80, "R3");
    boxed(16'h7F7F, "R3");
    idle(1);
    // R4: subnormals
    boxed(16'h0001, "R4");
    boxed(16'h807F, "R4");
    boxed(16'h0040, "R4");
    idle(2);
    // R6/R7: quiet and signalling NaNs
    boxed(16'h7FC0, "R6");
    boxed(16'hFFC5, "R6");
    boxed(16'h7FFF, "R6");
    boxed(16'h7F81, "R7");
    boxed(16'hFFBF, "R7");
    boxed(16'h7F80, "R7");
    idle(1);
    // R5: broken boxing, including an sNaN pattern underneath
    drive({32'hFFFF_FFFE, 32'h0000_3F80}, 3'd0, "R5");
    drive({32'h0000_0000, 32'h0000_7F81}, 3'd0, "R5");
    drive({32'hFFFF_FFFF, 32'h7FFF_0001}, 3'd0, "R5");
    drive({32'h7FFF_FFFF, 32'hFFFF_4049}, 3'd0, "R5");
    // R9: every rounding mode on the same operands
    for (int m = 0; m < 8; m++) begin
      drive({{(FLEN-16){1'b1}}, 16'h3EAB}, m[2:0], "R9");
      drive({{(FLEN-16){1'b1}}, 16'hFF81}, m[2:0], "R9");
    end
    // R8 is covered by every expected value above; R10 hold check
    idle(4);
    checks++;
    if (out_reg !== last_val) fail_line("R10", "hold while idle", out_reg, last_val);
    boxed(16'h4049, "R8");
    idle(3);
    checks++;
    if (out_reg !== last_val) fail_line("R10", "hold after single", out_reg, last_val);
    checks++;
    if (sb.size() != 0) fail_line("R2", "results outstanding", FLEN'(sb.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule